// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets software manage an Ethernet PHY over the two-wire management bus. Software first sets a port-enable bit in a control register, then writes one 32-bit management word that already holds every field of a clause-22 frame. The block sends 32 preamble ones and then the whole word, most significant bit first, on MDIO. It produces MDC by dividing the system clock.

On a read, the block lets go of MDIO partway through the turnaround field. It then samples the PHY's sixteen data bits on the rising edges of MDC. When the frame ends, those bits replace the low half of the management word. A status register shows an idle flag. Software polls that flag to learn when a frame has finished and when the result can be read back.

Register access uses a write strobe with a two-bit register select and 32-bit data. A separate combinational read port has its own select. MDIO appears as three signals: an output value, an output enable and an input value. The caller joins these into a tri-state pad.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control register reads 0, the management word reads 0, the status register reads 0x4 (idle, bit 2 set), MDC is low and the MDIO output enable is low; while idle MDC stays low and MDIO is not driven.
- R2: Control register bit 4 is the port enable (select 0). A management-word write (select 2) made while this bit is clear starts no frame and leaves the stored word unchanged.
- R3: A management-word write made while enabled and idle starts a frame. Status bit 2 (select 1) reads 0 from the next cycle and returns to 1 exactly 64×DIV cycles after that.
- R4: While a frame runs, MDC has a period of DIV system clocks (default 48). Each period is DIV/2 cycles low followed by DIV/2 cycles high, and starts low.
- R5: The frame is 32 ones followed by the 32 word bits from bit 31 down to bit 0. Each bit lasts one MDC period, and MDIO changes only when MDC goes low.
- R6: Word fields are start in bits 31:30 (01), operation in bits 29:28 (10 read, any other value drives the whole frame), PHY address in 27:23, register in 22:18, turnaround in 17:16 (10) and data in 15:0. All of them are sent unchanged, and a non-read frame leaves the stored word unchanged.
- R7: On a read the output enable drops at the start of word bit 16 (the second turnaround bit) and stays low to the end of the frame. On other frames it stays high for all 64 bits.
- R8: On a read, MDIO is sampled at each MDC rising edge of word bits 15..0, most significant bit first. At the end of the frame these bits replace word bits 15:0, and bits 31:16 stay as written.
- R9: A management-word write while a frame runs is ignored. The stored word does not change and the running frame continues unaltered.
- R10: Unused register bits and select 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select: 0 control, 1 status, 2 management word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Read select, same encoding |
| reg_rd_data | output | 32 | Read data for reg_rd_sel |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_in | input | 1 | MDIO pad value |

## Verification
The in-line assertions check the following on every cycle: MDC is high at each sample point, MDIO never changes while MDC is high, the line is quiet when idle, an early release of MDIO happens only on reads and lasts to the end of the frame, and writes made while disabled or busy have no effect. Other properties only the bench scenarios can show. These are the exact frame contents for chosen field values, the 64×DIV duration, and the captured read data, including all-ones and single-bit patterns, landing in the low half while the upper half is kept. The bench's behavioural model predicts MDC, MDIO, its enable and the register read-back on every clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_MAINT = 2'd2,
    REG_NONE  = 2'd3
  } mgmt_sel_e;

  localparam int CTRL_PORT_EN_BIT = 4;
  localparam int STAT_IDLE_BIT    = 2;
  localparam int OP_MSB           = 29;
  localparam int OP_LSB           = 28;
  localparam int TA_LOW_BIT       = 16;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic sample_tick,
  output logic bit_end_tick
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] HALF_C = CW'(DIV / 2);
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  always_comb begin
    if (!run || cnt_q == LAST_C) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    mdc_d = (cnt_d >= HALF_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc          = mdc_q;
  assign sample_tick  = run && (cnt_q == HALF_C);
  assign bit_end_tick = run && (cnt_q == LAST_C);

  AST_SAMPLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> mdc); // R4
  AST_BIT_END_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_tick |-> mdc); // R4
  AST_RISE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> sample_tick); // R4
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int WORD_W  = 32,
  parameter int RD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] load_word,
  input  logic              sample_tick,
  input  logic              bit_end_tick,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              is_read,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [RD_W-1:0]   cap_data
);
  localparam int TOTAL = PRE_LEN + WORD_W;
  localparam int PW    = $clog2(TOTAL);
  localparam logic [PW-1:0] PRE_C  = PW'(PRE_LEN);
  localparam logic [PW-1:0] LAST_C = PW'(TOTAL - 1);
  localparam logic [PW-1:0] REL_C  = PW'(PRE_LEN + WORD_W - 1 - TA_LOW_BIT);
  localparam logic [PW-1:0] DATA_C = PW'(TOTAL - RD_W);

  logic              busy_q, busy_d;
  logic              rd_q, rd_d;
  logic [PW-1:0]     pos_q, pos_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [RD_W-1:0]   cap_q, cap_d;
  logic              in_word;

  assign in_word = (pos_q >= PRE_C);
  assign done    = busy_q && bit_end_tick && (pos_q == LAST_C);

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    pos_d  = pos_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = (load_word[OP_MSB:OP_LSB] == OP_READ);
      pos_d  = '0;
      sh_d   = load_word;
      cap_d  = '0;
    end else if (busy_q) begin
      if (sample_tick && rd_q && pos_q >= DATA_C) begin
        cap_d = {cap_q[RD_W-2:0], mdio_in};
      end
      if (bit_end_tick) begin
        if (in_word) begin
          sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
        if (pos_q == LAST_C) begin
          busy_d = 1'b0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      pos_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      pos_q  <= pos_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = busy_q;
  assign is_read  = rd_q;
  assign cap_data = cap_q;
  assign mdio_oe  = busy_q && !(rd_q && pos_q >= REL_C);
  assign mdio_out = (!busy_q || !in_word) ? 1'b1 : sh_q[WORD_W-1];

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R3
  AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mdio_oe) |=> !mdio_oe); // R7
  AST_RELEASE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $fell(mdio_oe)) |-> is_read); // R7
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV     = 48,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic [1:0]  reg_rd_sel,
  output logic [31:0] reg_rd_data,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int WORD_W = 32;
  localparam int RD_W   = 16;

  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic              busy, done, is_read, sample_tick, bit_end_tick, start;
  logic [RD_W-1:0]   cap_data;
  logic              en_q, en_d;
  logic [WORD_W-1:0] maint_q, maint_d;
  logic              wr_maint, wr_ctrl;

  assign wr_maint = reg_wr && (mgmt_sel_e'(reg_wr_sel) == REG_MAINT);
  assign wr_ctrl  = reg_wr && (mgmt_sel_e'(reg_wr_sel) == REG_CTRL);
  assign start    = wr_maint && en_q && !busy;

  always_comb begin
    en_d    = en_q;
    maint_d = maint_q;
    if (wr_ctrl) begin
      en_d = reg_wr_data[CTRL_PORT_EN_BIT];
    end
    if (start) begin
      maint_d = reg_wr_data;
    end else if (done && is_read) begin
      maint_d[RD_W-1:0] = cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      maint_q <= '0;
    end else begin
      en_q    <= en_d;
      maint_q <= maint_d;
    end
  end

  always_comb begin
    reg_rd_data = '0;
    case (mgmt_sel_e'(reg_rd_sel))
      REG_CTRL:  reg_rd_data[CTRL_PORT_EN_BIT] = en_q;
      REG_STAT:  reg_rd_data[STAT_IDLE_BIT]    = !busy;
      REG_MAINT: reg_rd_data                   = maint_q;
      default:   reg_rd_data                   = '0;
    endcase
  end

  mdio_clk_div #(.DIV(DIV)) u_div (
    .clk          (clk),
    .rst_n        (rst_ni),
    .run          (busy),
    .mdc          (mdc),
    .sample_tick  (sample_tick),
    .bit_end_tick (bit_end_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN), .WORD_W(WORD_W), .RD_W(RD_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_ni),
    .start        (start),
    .load_word    (reg_wr_data),
    .sample_tick  (sample_tick),
    .bit_end_tick (bit_end_tick),
    .mdio_in      (mdio_in),
    .busy         (busy),
    .done         (done),
    .is_read      (is_read),
    .mdio_out     (mdio_out),
    .mdio_oe      (mdio_oe),
    .cap_data     (cap_data)
  );

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!mdc && !mdio_oe)); // R1
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_q && !busy) |=> !busy); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && wr_maint && !done) |=> $stable(maint_q)); // R9
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && $past(busy) && mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R5
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 48;
  localparam int FRAME_CYC  = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = 32'd0;
  logic [1:0]  reg_rd_sel = 2'd1;
  logic [31:0] reg_rd_data;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // behavioural reference state
  bit          busy_m = 0;
  bit          en_m = 0;
  bit          rd_m = 0;
  int          t_m = 0;
  logic [31:0] word_m = 0;
  logic [31:0] maint_m = 0;
  logic [15:0] phy_rsp = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy_m = 0; en_m = 0; rd_m = 0; t_m = 0; word_m = 0; maint_m = 0;
    end else begin
      bit start_m;
      start_m = reg_wr && reg_wr_sel == 2'd2 && en_m && !busy_m;
      if (busy_m) begin
        if (t_m == FRAME_CYC - 1) begin
          busy_m = 0;
          if (rd_m) maint_m[15:0] = phy_rsp;
        end else begin
          t_m++;
        end
      end else if (start_m) begin
        busy_m = 1; t_m = 0; word_m = reg_wr_data; maint_m = reg_wr_data;
        rd_m = (reg_wr_data[29:28] == 2'b10);
      end
      if (reg_wr && reg_wr_sel == 2'd0) en_m = reg_wr_data[4];
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // emulated PHY: drives turnaround zero then the response bits
  always @(negedge clk) begin
    int b;
    b = t_m / DIV;
    if (busy_m && rd_m && b >= 48) mdio_in = phy_rsp[63 - b];
    else if (busy_m && rd_m && b == 47) mdio_in = 1'b0;
    else mdio_in = 1'b1;
  end

  // per-cycle comparison a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && cyc > 4) begin
      int b;
      bit exp_mdc, exp_oe, exp_out;
      logic [31:0] exp_rd;
      b = t_m / DIV;
      exp_mdc = busy_m && ((t_m % DIV) >= DIV/2);
      exp_oe  = busy_m && !(rd_m && b >= 47);
      exp_out = (b < 32) ? 1'b1 : word_m[63 - b];
      case (reg_rd_sel)
        2'd0: exp_rd = {27'd0, en_m, 4'd0};
        2'd1: exp_rd = {29'd0, !busy_m, 2'd0};
        2'd2: exp_rd = maint_m;
        default: exp_rd = 32'd0;
      endcase
      check(mdc == exp_mdc, "R4 mdc", {31'd0, mdc}, {31'd0, exp_mdc});
      check(mdio_oe == exp_oe, "R7 mdio_oe", {31'd0, mdio_oe}, {31'd0, exp_oe});
      if (exp_oe) check(mdio_out == exp_out, "R5/R6 mdio_out", {31'd0, mdio_out}, {31'd0, exp_out});
      check(reg_rd_data == exp_rd, "R10 register read", reg_rd_data, exp_rd);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wr_sel = s; reg_wr_data = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_rd_sel = s;
    #1 v = reg_rd_data;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check(v == 32'd0, "R1 ctrl after reset", v, 32'd0);
    rd(2'd1, v); check(v == 32'h4, "R1 status after reset", v, 32'h4);
    rd(2'd2, v); check(v == 32'd0, "R1 word after reset", v, 32'd0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins quiet", {30'd0, mdc, mdio_oe}, 32'd0);
    rd(2'd3, v); check(v == 32'd0, "R10 select 3 reads zero", v, 32'd0);

    // R2 disabled write ignored
    wr(2'd2, 32'h1234_5678);
    repeat (10) @(negedge clk);
    rd(2'd1, v); check(v == 32'h4, "R2 still idle when disabled", v, 32'h4);
    rd(2'd2, v); check(v == 32'd0, "R2 word unchanged when disabled", v, 32'd0);
    check(mdc == 1'b0, "R2 no mdc when disabled", {31'd0, mdc}, 32'd0);

    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check(v == 32'h10, "R2 enable bit readback", v, 32'h10);

    // R3 R6 write frame
    w = mk(2'b01, 5'd11, 5'd4, 16'hA5C3);
    wr(2'd2, w);
    rd(2'd1, v); check(v == 32'd0, "R3 busy after start", v, 32'd0);
    repeat (FRAME_CYC - 5) @(negedge clk);
    rd(2'd1, v); check(v == 32'd0, "R3 busy just before end", v, 32'd0);
    repeat (4) @(negedge clk);
    rd(2'd1, v); check(v == 32'h4, "R3 idle after frame", v, 32'h4);
    rd(2'd2, v); check(v == w, "R6 write word unchanged", v, w);

    // R8 read frame
    phy_rsp = 16'h796D;
    w = mk(2'b10, 5'd1, 5'd1, 16'h0000);
    wr(2'd2, w);
    repeat (FRAME_CYC + 4) @(negedge clk);
    rd(2'd2, v); check(v == {w[31:16], 16'h796D}, "R8 read data captured", v, {w[31:16], 16'h796D});

    // R9 write while busy
    phy_rsp = 16'hFFFF;
    w = mk(2'b10, 5'd31, 5'd0, 16'h0000);
    wr(2'd2, w);
    repeat (100) @(negedge clk);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd2, v); check(v == w, "R9 busy write ignored", v, w);
    repeat (FRAME_CYC) @(negedge clk);
    rd(2'd2, v); check(v == {w[31:16], 16'hFFFF}, "R8 all-ones read", v, {w[31:16], 16'hFFFF});

    // R8 single-bit response overwrites nonzero data field
    phy_rsp = 16'h0001;
    w = mk(2'b10, 5'd0, 5'd31, 16'hFFFF);
    wr(2'd2, w);
    repeat (FRAME_CYC + 4) @(negedge clk);
    rd(2'd2, v); check(v == {w[31:16], 16'h0001}, "R8 single-bit read", v, {w[31:16], 16'h0001});

    // R6 other op code drives full frame
    w = mk(2'b00, 5'd21, 5'd10, 16'h0F0F);
    wr(2'd2, w);
    repeat (FRAME_CYC + 4) @(negedge clk);
    rd(2'd2, v); check(v == w, "R6 non-read word kept", v, w);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule